// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block counts cycles of the prescaled oscillator clock. Each division cycle lasts either R or R+1 clocks, where R is the programmed integer ratio. A small modulo accumulator picks the longer count, so the long-run ratio is R plus INC/Q. The modulus Q is 5 or 8. At the end of every division cycle the block emits a one-clock output pulse and adds the increment to the accumulator. When that sum reaches Q, it subtracts Q and stretches the next division cycle by one clock.

A new ratio, increment and modulus arrive together with a load strobe. While the divider runs, they wait in a holding register and take effect only where one division cycle ends. When they do, the accumulator starts again from zero. Each output pulse also opens a compensation window of fixed length. During that window the block drives a compensation magnitude: the accumulator value multiplied by a gain code. The recommended gain code is 128 for modulus 5 and 80 for modulus 8.

The run controller has two states. RUN_OFF moves to RUN_ON when enable is high, and RUN_ON returns to RUN_OFF when enable is low. The compensation window has two states. WIN_IDLE moves to WIN_OPEN on an output pulse. WIN_OPEN returns to WIN_IDLE once its counter expires, or at once when enable drops.

Top module: `fracn_main_div`

## Requirements
- R1: While enable is low, and after reset, div_pulse and comp_en are 0, acc_val is 0 and comp_mag is 0.
- R2: div_pulse is high for exactly one clock per division cycle. The first pulse comes R+1 falling edges after the edge at which enable is first seen high.
- R3: Each division cycle lasts R clocks plus the carry. At each pulse, acc_val becomes (acc + INC) mod Q, and the carry is 1 exactly when acc + INC >= Q.
- R4: mod5_sel = 1 selects Q = 5 and mod5_sel = 0 selects Q = 8.
- R5: An increment value at or above Q is treated as Q-1.
- R6: A ratio below MIN_RATIO (512) is treated as MIN_RATIO, so no two pulses are closer than 512 clocks.
- R7: A load while the divider runs does not change the current cycle. At the next boundary the new settings apply, and acc_val and the carry restart at 0. A load while disabled applies at once.
- R8: comp_en goes high in the same clock as div_pulse and stays high for exactly COMP_LEN (128) clocks.
- R9: comp_mag equals acc_val times comp_gain while comp_en is high, and 0 otherwise.
- R10: Within any Q consecutive division cycles, exactly INC of them (after clamping) last R+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider when high |
| load | input | 1 | Load strobe for ratio_in, inc_in and mod5_sel |
| ratio_in | input | 16 | Integer division ratio R |
| inc_in | input | 3 | Fractional increment INC |
| mod5_sel | input | 1 | Modulus select: 1 gives Q = 5, 0 gives Q = 8 |
| comp_gain | input | 8 | Compensation gain code |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| acc_val | output | 3 | Current accumulator value |
| comp_en | output | 1 | Compensation window |
| comp_mag | output | 11 | Compensation magnitude |

## Verification
The bench runs every increment value under both moduli at the minimum ratio. Against an arithmetic model it checks every pulse interval, every accumulator value, the window length and the magnitude in every clock. An off-by-one terminal count or a wrong wrap point would show up as a wrong period, and a carry applied one cycle late would shift the N+1 cycles. Increments above Q-1 under modulus 5 catch a missing clamp, which would leave the accumulator out of range and give too many long cycles. A load placed mid-cycle catches a reload that cuts the running cycle short or fails to restart the accumulator. A ratio below 512 and a long idle stretch with enable low check the floor on the ratio and the quiet disabled state.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int RATIO_W = 16;
    localparam int INC_W   = 3;
    localparam int ACC_W   = 3;

    typedef enum logic {RUN_OFF, RUN_ON}    run_state_t;
    typedef enum logic {WIN_IDLE, WIN_OPEN} win_state_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [INC_W-1:0]   inc;
        logic               mod5;
    } div_cfg_t;

    // Increment limited to modulus-1 (only modulus 5 can be exceeded)
    function automatic logic [INC_W-1:0] clamp_inc(input logic [INC_W-1:0] inc,
                                                   input logic mod5);
        if (mod5 && inc > INC_W'(4))
            return INC_W'(4);
        return inc;
    endfunction

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [INC_W-1:0] inc,
    input  logic             mod5,
    output logic [ACC_W-1:0] acc,
    output logic             carry
);

    logic [ACC_W:0] sum;
    logic [ACC_W:0] modq;
    logic           wrap;
    logic [ACC_W:0] nxt;

    always_comb begin
        sum  = {1'b0, acc} + {{(ACC_W+1-INC_W){1'b0}}, inc};
        modq = mod5 ? (ACC_W+1)'(5) : (ACC_W+1)'(8);
        wrap = (sum >= modq);
        nxt  = wrap ? (sum - modq) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            carry <= 1'b0;
        end else if (clear) begin
            acc   <= '0;
            carry <= 1'b0;
        end else if (step) begin
            acc   <= nxt[ACC_W-1:0];
            carry <= wrap;
        end
    end

endmodule

// File: rtl/fracn_reload.sv
module fracn_reload
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic               boundary,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [INC_W-1:0]   inc_in,
    input  logic               mod5_in,
    output div_cfg_t           act,
    output logic               apply
);

    localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);

    div_cfg_t req_cfg;
    div_cfg_t pend_q;
    logic     pend_v;

    always_comb begin
        req_cfg.ratio = (ratio_in < MIN_R) ? MIN_R : ratio_in;
        req_cfg.inc   = clamp_inc(inc_in, mod5_in);
        req_cfg.mod5  = mod5_in;
        apply         = running && boundary && (pend_v || load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act    <= '{ratio: MIN_R, inc: '0, mod5: 1'b0};
            pend_q <= '{ratio: MIN_R, inc: '0, mod5: 1'b0};
            pend_v <= 1'b0;
        end else if (!running) begin
            if (load)
                act <= req_cfg;
            else if (pend_v)
                act <= pend_q;
            pend_v <= 1'b0;
        end else if (apply) begin
            act    <= load ? req_cfg : pend_q;
            pend_v <= 1'b0;
        end else if (load) begin
            pend_q <= req_cfg;
            pend_v <= 1'b1;
        end
    end

endmodule

// File: rtl/fracn_comp_window.sv
module fracn_comp_window
    import fracn_pkg::*;
#(
    parameter int LEN = 128   // at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic active
);

    localparam int           CW_W = $clog2(LEN);
    localparam logic [CW_W-1:0] LAST = CW_W'(LEN - 1);

    win_state_t      state_q, state_d;
    logic [CW_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: if (start) state_d = WIN_OPEN;
            WIN_OPEN: if (cnt_q == '0 && !start) state_d = WIN_IDLE;
        endcase
        if (clear)
            state_d = WIN_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clear)
                cnt_q <= '0;
            else if (start)
                cnt_q <= LAST;
            else if (state_q == WIN_OPEN && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb active = (state_q == WIN_OPEN);

endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO = 512,
    parameter int COMP_LEN  = 128,
    parameter int GAIN_W    = 8,
    localparam int MAG_W    = ACC_W + GAIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [INC_W-1:0]   inc_in,
    input  logic               mod5_sel,
    input  logic [GAIN_W-1:0]  comp_gain,
    output logic               div_pulse,
    output logic [ACC_W-1:0]   acc_val,
    output logic               comp_en,
    output logic [MAG_W-1:0]   comp_mag
);

    run_state_t         state_q, state_d;
    div_cfg_t           act;
    logic               apply;
    logic               running;
    logic               live;
    logic               carry;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W:0]   last_cnt;
    logic               terminal;

    always_comb begin
        running  = (state_q == RUN_ON);
        live     = running && enable;
        last_cnt = {1'b0, act.ratio} + {{RATIO_W{1'b0}}, carry} - 1'b1;
        terminal = live && ({1'b0, cnt_q} == last_cnt);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_OFF: if (enable)  state_d = RUN_ON;
            RUN_ON:  if (!enable) state_d = RUN_OFF;
        endcase
    end

    // cycle counter and output pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= terminal;
            if (!live || terminal)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    fracn_reload #(.MIN_RATIO(MIN_RATIO)) reload_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .boundary (terminal),
        .load     (load),
        .ratio_in (ratio_in),
        .inc_in   (inc_in),
        .mod5_in  (mod5_sel),
        .act      (act),
        .apply    (apply)
    );

    fracn_accum accum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!live || apply),
        .step  (terminal),
        .inc   (act.inc),
        .mod5  (act.mod5),
        .acc   (acc_val),
        .carry (carry)
    );

    fracn_comp_window #(.LEN(COMP_LEN)) window_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!enable),
        .start  (terminal),
        .active (comp_en)
    );

    always_comb
        comp_mag = comp_en ? ({{GAIN_W{1'b0}}, acc_val} * {{ACC_W{1'b0}}, comp_gain}) : '0;

endmodule

// File: rtl/fracn_main_div_chk.sv
module fracn_main_div_chk #(
    parameter int MIN_RATIO = 512,
    parameter int COMP_LEN  = 128,
    parameter int MAG_W     = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             div_pulse,
    input logic [2:0]       acc_val,
    input logic             comp_en,
    input logic [MAG_W-1:0] comp_mag
);

    localparam int WL_W = $clog2(COMP_LEN) + 2;

    logic [WL_W-1:0] win_len;
    logic [16:0]     gap;
    logic            seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_len <= '0;
            gap     <= '0;
            seen    <= 1'b0;
        end else begin
            win_len <= comp_en ? win_len + 1'b1 : '0;
            if (!enable) begin
                seen <= 1'b0;
                gap  <= '0;
            end else if (div_pulse) begin
                seen <= 1'b1;
                gap  <= 17'd1;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!div_pulse && acc_val == '0 && !comp_en));

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_acc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_val) |-> (div_pulse || !$past(enable)));

    assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && seen) |-> (gap >= 17'(MIN_RATIO)));

    assert_window_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comp_en) |-> div_pulse);

    assert_window_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(comp_en) && $past(enable)) |-> (win_len == WL_W'(COMP_LEN)));

    assert_mag_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_en |-> (comp_mag == '0));

endmodule

bind fracn_main_div fracn_main_div_chk #(
    .MIN_RATIO (MIN_RATIO),
    .COMP_LEN  (COMP_LEN),
    .MAG_W     (MAG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .div_pulse (div_pulse),
    .acc_val   (acc_val),
    .comp_en   (comp_en),
    .comp_mag  (comp_mag)
);

// File: tb/fracn_main_div_tb.sv
module fracn_main_div_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MINR       = 512;
    localparam int WIN        = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        load = 1'b0;
    logic [15:0] ratio_in = 16'd512;
    logic [2:0]  inc_in = 3'd0;
    logic        mod5_sel = 1'b0;
    logic [7:0]  comp_gain = 8'd0;
    logic        div_pulse;
    logic [2:0]  acc_val;
    logic        comp_en;
    logic [10:0] comp_mag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_acc, m_carry, m_q, m_inc, m_ratio, m_gain;

    always #(CLK_PERIOD/2) clk = ~clk;

    fracn_main_div dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .load(load),
        .ratio_in(ratio_in), .inc_in(inc_in), .mod5_sel(mod5_sel),
        .comp_gain(comp_gain), .div_pulse(div_pulse), .acc_val(acc_val),
        .comp_en(comp_en), .comp_mag(comp_mag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int sum;
        sum     = m_acc + m_inc;
        m_carry = (sum >= m_q) ? 1 : 0;
        m_acc   = m_carry ? sum - m_q : sum;
    endtask

    // counts falling edges up to the next pulse; tallies window and magnitude
    task automatic to_pulse(inout int t, output int wins, output int bad);
        wins = 0;
        bad  = 0;
        forever begin
            if (comp_en) wins++;
            if (int'(comp_mag) != (comp_en ? m_acc * m_gain : 0)) bad++;
            @(negedge clk);
            t++;
            if (div_pulse) break;
        end
    endtask

    task automatic run_cfg(input int n, input int inc, input bit m5, input int gain, input int cycles);
        int t, wins, bad, per, plus;
        string tag;
        enable = 1'b0;
        repeat (2) @(negedge clk);
        ratio_in = 16'(n); inc_in = 3'(inc); mod5_sel = m5; comp_gain = 8'(gain);
        load = 1'b1;
        @(negedge clk);
        load   = 1'b0;
        enable = 1'b1;
        m_q     = m5 ? 5 : 8;
        m_inc   = (inc >= m_q) ? m_q - 1 : inc;
        m_ratio = (n < MINR) ? MINR : n;
        m_gain  = gain;
        m_acc   = 0;
        m_carry = 0;
        plus    = 0;
        tag = (inc >= m_q) ? "R5" : (m5 ? "R4" : "R3");
        t = 0;
        forever begin
            @(negedge clk);
            t++;
            if (div_pulse) break;
        end
        chk((n < MINR) ? "R6 first pulse" : "R2 first pulse", t, m_ratio + 1);
        model_step();
        chk(tag, acc_val, m_acc);
        for (int i = 1; i < cycles; i++) begin
            per = m_ratio + m_carry;
            if (i <= m_q && m_carry == 1) plus++;
            t = 0;
            to_pulse(t, wins, bad);
            chk((n < MINR) ? "R6 period" : "R3 period", t, per);
            chk("R8 window", wins, WIN);
            chk("R9 magnitude", bad, 0);
            model_step();
            chk(tag, acc_val, m_acc);
        end
        if (cycles > m_q)
            chk("R10 long cycles", plus, m_inc);
    endtask

    initial begin
        int t, wins, bad, cnt;
        repeat (3) @(negedge clk);
        chk("R1 reset pulse", div_pulse, 0);
        chk("R1 reset acc", acc_val, 0);
        chk("R1 reset window", comp_en, 0);
        chk("R1 reset mag", comp_mag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 8; k++)
                run_cfg(512, k, m[0], m ? 128 : 80, (m ? 5 : 8) + 1);

        run_cfg(100, 3, 1'b0, 255, 3);
        run_cfg(700, 6, 1'b1, 200, 6);

        // R7: mid-cycle reload
        run_cfg(512, 3, 1'b1, 128, 2);
        t = 0;
        cnt = 0;
        repeat (100) begin
            @(negedge clk);
            t++;
            if (div_pulse) cnt++;
        end
        ratio_in = 16'd600; inc_in = 3'd1; mod5_sel = 1'b0;
        load = 1'b1;
        @(negedge clk);
        t++;
        load = 1'b0;
        to_pulse(t, wins, bad);
        chk("R7 early pulse", cnt, 0);
        chk("R7 current cycle kept", t, 512 + m_carry);
        chk("R7 acc restart", acc_val, 0);
        m_acc = 0; m_carry = 0; m_q = 8; m_inc = 1; m_ratio = 600;
        t = 0;
        to_pulse(t, wins, bad);
        chk("R7 new ratio", t, 600);
        chk("R7 new increment", acc_val, 1);

        // R1: disabled stays quiet
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable acc", acc_val, 0);
        chk("R1 disable window", comp_en, 0);
        cnt = 0;
        repeat (700) begin
            @(negedge clk);
            if (div_pulse || comp_en || comp_mag != 0) cnt++;
        end
        chk("R1 idle activity", cnt, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual hung expected pulses");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule